// File: doc/BRIEF.md
# Free-Running 64-bit Time Base with Coherent Capture

This block keeps a 64-bit up-counter that advances by one on every clock from reset onward and never stops. A host on a 32-bit register port sees the live count as two words. Because the two words cannot be fetched in one access, the block offers a capture command. A single control write copies the whole count into a pair of read-only capture words. These hold still until the next capture, so the host can read them high word first and then low word and always get one consistent 64-bit value.

The host can also move the count to any 64-bit value. It writes the value into two staging words and then issues a commit command through the control word. The counter takes the staged value on the commit edge and keeps counting up from there. The clock is always used undivided. A control value of zero therefore means "plain counting, no command". Both command bits are one-shot: they act on the cycle of the write and always read back as zero.

Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. Word offsets are CTRL 0x00, COUNT_LO 0x04, COUNT_HI 0x08, STAGE_LO 0x0C, STAGE_HI 0x10, CAPT_LO 0x14 and CAPT_HI 0x18.

Top module: `tsc_free_counter`

## Requirements
- R1: While reset is high and on leaving reset, the count, both staging words and both capture words read as zero.
- R2: Outside reset and with no commit, the 64-bit count rises by exactly one on every clock edge.
- R3: The count carries from the low word into the high word, and after the all-ones value it wraps to zero on the next edge.
- R4: A CTRL write with bit 0 = 1 and bit 1 = 0 copies the count value present at that write edge into CAPT_HI:CAPT_LO. The copy is readable from the cycle after that edge.
- R5: The capture words keep their value until the next capture command. Counting, staging writes and commits leave them unchanged.
- R6: A CTRL write with bit 0 = 1 and bit 1 = 1 makes the count equal to STAGE_HI:STAGE_LO right after that edge. The count then rises by one per edge from that value.
- R7: STAGE_LO and STAGE_HI can be written and read back. Writing them does not alter the count.
- R8: CTRL always reads as zero. A CTRL write with bit 0 = 0 (for example the value 0x2) neither captures nor commits.
- R9: COUNT_LO and COUNT_HI are read-only. Writes to them are ignored.
- R10: Reads of unmapped or misaligned addresses (low two bits nonzero) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, acted on at the rising edge |
| wr_addr | input | ADDR_W (5) | Byte address of the write |
| wr_data | input | BUS_W (32) | Write data |
| rd_addr | input | ADDR_W (5) | Byte address of the read |
| rd_data | output | BUS_W (32) | Combinational read data for rd_addr |

## Verification
A commit or a capture acts on the edge where the CTRL write is sampled. The new count or the new capture words are therefore visible on `rd_data` from just after that edge, and the count steps once more on each later edge. Staging and register writes also land on the write edge, with no extra pipeline stage, and reads are combinational. For this reason the bench drives a request at a falling edge and reads the result at the falling edge after the write edge. A behavioural 64-bit model, updated on each rising edge, is compared with the read port 2 ns after every rising edge.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // Word indices of the register map (byte offset = 4 * index).
    localparam int W_CTRL     = 0;
    localparam int W_COUNT_LO = 1;
    localparam int W_COUNT_HI = 2;
    localparam int W_STAGE_LO = 3;
    localparam int W_STAGE_HI = 4;
    localparam int W_CAPT_LO  = 5;
    localparam int W_CAPT_HI  = 6;

    // Command bit positions inside the control word.
    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_LOAD_BIT = 1;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_COUNT_LO,
        SEL_COUNT_HI,
        SEL_STAGE_LO,
        SEL_STAGE_HI,
        SEL_CAPT_LO,
        SEL_CAPT_HI,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_CAPTURE,
        CMD_COMMIT
    } cmd_e;

    typedef struct packed {
        logic     en;
        reg_sel_e sel;
    } wr_req_t;

    function automatic cmd_e decode_cmd(input logic go, input logic load);
        cmd_e c;
        if (!go)       c = CMD_NONE;
        else if (load) c = CMD_COMMIT;
        else           c = CMD_CAPTURE;
        return c;
    endfunction

    function automatic reg_sel_e sel_of_word(input int idx);
        reg_sel_e s;
        case (idx)
            W_CTRL:     s = SEL_CTRL;
            W_COUNT_LO: s = SEL_COUNT_LO;
            W_COUNT_HI: s = SEL_COUNT_HI;
            W_STAGE_LO: s = SEL_STAGE_LO;
            W_STAGE_HI: s = SEL_STAGE_HI;
            W_CAPT_LO:  s = SEL_CAPT_LO;
            W_CAPT_HI:  s = SEL_CAPT_HI;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tsc_stage_regs.sv
module tsc_stage_regs
    import tsc_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wr_req_t              req,
    input  logic [BUS_W-1:0]     wr_data,
    output logic [2*BUS_W-1:0]   stage_val
);
    localparam int NHALF = 2;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        localparam reg_sel_e MY_SEL = (h == 0) ? SEL_STAGE_LO : SEL_STAGE_HI;
        logic [BUS_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (req.en && req.sel == MY_SEL) begin
                q <= wr_data;
            end
        end

        assign stage_val[h*BUS_W +: BUS_W] = q;
    end

endmodule

// File: rtl/tsc_count_core.sv
module tsc_count_core
    import tsc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic [CNT_W-1:0] stage_val,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cmd == CMD_COMMIT) begin
            count <= stage_val;
        end else begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/tsc_capture_regs.sv
module tsc_capture_regs
    import tsc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            capt <= '0;
        end else if (cmd == CMD_CAPTURE) begin
            capt <= count;
        end
    end
endmodule

// File: rtl/tsc_free_counter.sv
module tsc_free_counter
    import tsc_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data
);
    localparam int CNT_W = 2 * BUS_W;

    function automatic reg_sel_e sel_of_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a[1:0] != 2'b00) s = SEL_NONE;
        else                 s = sel_of_word(int'(a >> 2));
        return s;
    endfunction

    wr_req_t          req;
    reg_sel_e         rd_sel;
    cmd_e             cmd;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] stage_val;
    logic [CNT_W-1:0] capt;

    assign req.en  = wr_en;
    assign req.sel = sel_of_addr(wr_addr);
    assign rd_sel  = sel_of_addr(rd_addr);

    assign cmd = (req.en && req.sel == SEL_CTRL)
               ? decode_cmd(wr_data[CMD_GO_BIT], wr_data[CMD_LOAD_BIT])
               : CMD_NONE;

    tsc_stage_regs #(.BUS_W(BUS_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wr_data   (wr_data),
        .stage_val (stage_val)
    );

    tsc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .stage_val (stage_val),
        .count     (count)
    );

    tsc_capture_regs #(.CNT_W(CNT_W)) u_capt (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .count (count),
        .capt  (capt)
    );

    always_comb begin
        case (rd_sel)
            SEL_COUNT_LO: rd_data = count[BUS_W-1:0];
            SEL_COUNT_HI: rd_data = count[CNT_W-1:BUS_W];
            SEL_STAGE_LO: rd_data = stage_val[BUS_W-1:0];
            SEL_STAGE_HI: rd_data = stage_val[CNT_W-1:BUS_W];
            SEL_CAPT_LO:  rd_data = capt[BUS_W-1:0];
            SEL_CAPT_HI:  rd_data = capt[CNT_W-1:BUS_W];
            default:      rd_data = '0;   // CTRL and unmapped read zero
        endcase
    end

endmodule

// File: rtl/tsc_free_counter_chk.sv
module tsc_free_counter_chk
    import tsc_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic                 clk,
    input logic                 rst,
    input cmd_e                 cmd,
    input logic [2*BUS_W-1:0]   count,
    input logic [2*BUS_W-1:0]   stage_val,
    input logic [2*BUS_W-1:0]   capt,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic [BUS_W-1:0]     rd_data
);
    localparam int CNT_W = 2 * BUS_W;

    // R2, R3: plain increment (modulo 2^CNT_W) when no commit was issued
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd) != CMD_COMMIT) |-> count == $past(count) + CNT_W'(1));

    // R6: commit places the staged value into the count
    a_r6_commit_takes_stage: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_COMMIT) |=> count == $past(stage_val));

    // R4: capture copies the count seen at the command edge
    a_r4_capture_copies: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CAPTURE) |=> capt == $past(count));

    // R5: capture words hold without a capture command
    a_r5_capture_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_CAPTURE) |=> $stable(capt));

    // R8: control word reads as zero
    a_r8_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0) |-> rd_data == '0);

endmodule

bind tsc_free_counter tsc_free_counter_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .count     (count),
    .stage_val (stage_val),
    .capt      (capt),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/tsc_free_counter_bench.sv
module tsc_free_counter_bench;

    localparam logic [4:0] A_CTRL = 5'h00, A_CLO = 5'h04, A_CHI = 5'h08,
                           A_SLO = 5'h0C, A_SHI = 5'h10, A_KLO = 5'h14, A_KHI = 5'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R1";

    bit [63:0] m_cnt = '0, m_stage = '0, m_capt = '0;

    always #4 clk = ~clk;   // 125 MHz

    tsc_free_counter u_tsc_free_counter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] a);
        case (a)
            A_CLO:   return m_cnt[31:0];
            A_CHI:   return m_cnt[63:32];
            A_SLO:   return m_stage[31:0];
            A_SHI:   return m_stage[63:32];
            A_KLO:   return m_capt[31:0];
            A_KHI:   return m_capt[63:32];
            default: return 32'h0;
        endcase
    endfunction

    // Behavioural reference, updated on every rising edge.
    always @(posedge clk) begin
        bit [63:0] nxt;
        if (rst) begin
            m_cnt = '0; m_stage = '0; m_capt = '0;
        end else begin
            nxt = m_cnt + 64'd1;
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL: if (wr_data[0]) begin
                                if (wr_data[1]) nxt = m_stage;
                                else            m_capt = m_cnt;
                            end
                    A_SLO:  m_stage[31:0]  = wr_data;
                    A_SHI:  m_stage[63:32] = wr_data;
                    default: ;
                endcase
            end
            m_cnt = nxt;
        end
    end

    // Per-clock comparison of the read port against the model.
    always @(posedge clk) begin
        #2;
        if (!done) check(phase, rd_data, model_read(rd_addr));
    end

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, a, b, klo, khi;

        // R1: reset state
        repeat (3) @(negedge clk);
        rd(A_CLO, v); check("R1", v, 32'h0);
        rd(A_KHI, v); check("R1", v, 32'h0);
        rd(A_SLO, v); check("R1", v, 32'h0);
        rst = 1'b0;

        // R2: free-running increment
        phase = "R2";
        @(negedge clk); rd(A_CLO, a);
        repeat (10) @(negedge clk);
        rd(A_CLO, b); check("R2", b, a + 32'd10);

        // R7: staging words read back
        phase = "R7";
        wr(A_SLO, 32'hFFFF_FFFF);
        wr(A_SHI, 32'h0);
        rd(A_SLO, v); check("R7", v, 32'hFFFF_FFFF);
        rd(A_SHI, v); check("R7", v, 32'h0);

        // R6 then R3 carry from low into high word
        phase = "R6";
        wr(A_CTRL, 32'h3);
        rd(A_CLO, v); check("R6", v, 32'hFFFF_FFFF);
        rd(A_CHI, v); check("R6", v, 32'h0);
        phase = "R3";
        @(negedge clk);
        rd(A_CLO, v); check("R3", v, 32'h0);
        rd(A_CHI, v); check("R3", v, 32'h1);

        // R3 wrap at 2^64
        wr(A_SHI, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h3);
        rd(A_CHI, v); check("R3", v, 32'hFFFF_FFFF);
        rd(A_CLO, v); check("R3", v, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(A_CHI, v); check("R3", v, 32'h0);
        rd(A_CLO, v); check("R3", v, 32'h0);

        // R4: capture the count present at the write edge
        phase = "R4";
        repeat (5) @(negedge clk);
        rd(A_CLO, klo); rd(A_CHI, khi);
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = 32'h1;
        @(negedge clk); wr_en = 1'b0;
        rd(A_KHI, v); check("R4", v, khi);
        rd(A_KLO, v); check("R4", v, klo);

        // R5: capture holds across counting, staging and commit
        phase = "R5";
        repeat (20) @(negedge clk);
        rd(A_KHI, v); check("R5", v, khi);
        wr(A_SLO, 32'd123);
        wr(A_CTRL, 32'h3);
        rd(A_KHI, v); check("R5", v, khi);
        rd(A_KLO, v); check("R5", v, klo);

        // R8: control reads zero; bit 1 alone does nothing
        phase = "R8";
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R8", v, 32'h0);
        rd(A_CLO, a);
        wr(A_CTRL, 32'h2);
        rd(A_CLO, v); check("R8", v, a + 32'd2);
        rd(A_KLO, v); check("R8", v, klo);
        rd(A_CTRL, v); check("R8", v, 32'h0);

        // R9: live count words ignore writes
        phase = "R9";
        rd(A_CLO, a);
        wr(A_CLO, 32'h0);
        rd(A_CLO, v); check("R9", v, a + 32'd2);
        rd(A_CHI, a);
        wr(A_CHI, 32'h5555_0000);
        rd(A_CHI, v); check("R9", v, a);

        // R10: unmapped and misaligned reads
        phase = "R10";
        @(negedge clk);
        rd(5'h1C, v); check("R10", v, 32'h0);
        rd(5'h06, v); check("R10", v, 32'h0);
        @(negedge clk);
        finish_run();
    end

endmodule